// File: doc/BRIEF.md
# Paged Serial EEPROM Target

This block is the target side of a two-wire serial bus (I2C) in front of a 1024-byte memory array. It watches the clock and data lines through synchronisers and finds START and STOP conditions. It shifts bytes in and out, most significant bit first. It acknowledges only the device addresses that belong to it. The data line is open-drain: the block can only pull it low, and an external pull-up gives the high level.

The upper memory address bits do not travel in the word-address byte. Instead, the two low bits of the 7-bit device address carry them. A write gives one word-address byte and then data bytes. The data bytes are held in a page buffer. They reach the array only during a self-timed write cycle, which starts at a STOP that follows at least one data byte. During that cycle the block does not acknowledge its own address, so the host polls until the address is acknowledged again.

A read uses an internal address pointer. A write transaction that carries only a word address, followed by a repeated START, turns the next read into a random read. A read with no address phase continues from wherever the last transaction left the pointer.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset the block does not pull SDA low, and it acknowledges its device address at once, because no write cycle is running.
- R2: The block acknows its device address when bits 6:4 and bit 2 of the 7-bit address equal the base (default 1010_0xx) and bit 3 is 0. Address bits 1:0 become memory address bits 9:8. Any other address gets no acknowledge.
- R3: A device address with bit 3 set (the register space) gets no acknowledge and leaves the array unchanged.
- R4: In a write, the first byte after the device address is the word address (memory address bits 7:0). Each following data byte is acknowledged and lands at the current address.
- R5: Within a write, the address advances only in bits 3:0 and wraps inside the 16-byte page, while bits 9:4 stay fixed. When more than 16 bytes are sent, the later bytes overwrite the earlier ones at the same page offset.
- R6: Data is committed only at a STOP that follows at least one data byte. A STOP right after the word address, or a repeated START, leaves the array unchanged and starts no write cycle.
- R7: After a committing STOP, the write cycle lasts WR_CYCLES clock cycles. During it, every device address gets no acknowledge. Once it ends, the address is acknowledged again.
- R8: A random read returns the byte stored at the given address. A random read is a write of only the word address, then a repeated START with R/W = 1.
- R9: During a read, the pointer advances by one after each byte and rolls over from 1023 to 0. A host NAK ends the read. A later read with no address phase continues from the pointer.
- R10: The block changes its SDA drive only while SCL is low, and it only ever pulls SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND) |
| sda_pull | output | 1 | 1 = pull SDA low; 0 = release it |

## Verification
The main function is tried with several kinds of transaction:
- single-byte writes with different upper-address bits, which show whether the device-address bits reach address bits 9:8;
- a full aligned page, which shows sequential loading;
- a write that starts near the end of a page, which separates page wrap from a carry into bit 4;
- an 18-byte write, which shows that extra bytes overwrite the earlier ones.

Reads are made as random reads, as current-address reads and as a two-byte read across address 1023, so that pointer reload, pointer carry-over between transactions and rollover each show up on their own. Polling right after a STOP tells a committing write apart from a STOP with no data and from a repeated START. Foreign addresses and register-space addresses are each checked against the expected silence on the bus.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    LS_IDLE,
    LS_DEV,
    LS_DEV_ACK,
    LS_WADDR,
    LS_WADDR_ACK,
    LS_WDATA,
    LS_WDATA_ACK,
    LS_RDATA,
    LS_RACK
  } link_state_t;
endpackage

// File: rtl/eep_edge.sv
// Line synchronisers plus bus event detection (edges, START, STOP).
module eep_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [LINES-1:0] raw, cur, prv;
  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], raw[g]};
    end
    assign cur[g] = chain_q[STAGES-1];
    assign prv[g] = chain_q[STAGES];
  end

  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/eep_link.sv
// Byte-level protocol engine: address decode, ack, pointer, shift in/out.
module eep_link
  import eep_pkg::*;
#(
  parameter int         AW       = 10,
  parameter int         PAGE_AW  = 4,
  parameter logic [6:0] DEV_BASE = 7'h50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic                    sda_s,
  input  logic                    busy,
  input  logic [7:0]              rd_data,
  output logic                    sda_pull,
  output logic [AW-1:0]           ptr,
  output logic                    buf_clr,
  output logic                    buf_we,
  output logic [PAGE_AW-1:0]      buf_idx,
  output logic [7:0]              buf_data,
  output logic                    commit,
  output logic [AW-PAGE_AW-1:0]   commit_page,
  output logic                    dev_ack
);
  localparam int         HI         = AW - 8;
  localparam logic [6:0] HI_MASK    = 7'((1 << HI) - 1);
  localparam logic [6:0] MATCH_MASK = ~(HI_MASK | 7'h08);

  link_state_t    st_q, st_d;
  logic [7:0]     sh_q, sh_d, tx_q, tx_d;
  logic [3:0]     cnt_q, cnt_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic           rw_q, rw_d, have_q, have_d, mack_q, mack_d, pull_q, pull_d;

  logic [6:0] dev7;
  logic       addr_hit, byte_done;

  assign dev7      = sh_q[7:1];
  assign addr_hit  = (((dev7 ^ DEV_BASE) & MATCH_MASK) == 7'h00) && !dev7[3];
  assign byte_done = scl_fall && (cnt_q == 4'd8);

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    have_d  = have_q;
    mack_d  = mack_q;
    pull_d  = pull_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    commit  = 1'b0;
    dev_ack = 1'b0;

    if (start_det) begin
      st_d   = LS_DEV;
      cnt_d  = '0;
      pull_d = 1'b0;
      have_d = 1'b0;
    end else if (stop_det) begin
      commit = have_q;
      have_d = 1'b0;
      st_d   = LS_IDLE;
      pull_d = 1'b0;
    end else begin
      unique case (st_q)
        LS_DEV, LS_WADDR, LS_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (byte_done) begin
            if (st_q == LS_DEV) begin
              if (addr_hit && !busy) begin
                dev_ack           = 1'b1;
                pull_d            = 1'b1;
                rw_d              = sh_q[0];
                ptr_d[AW-1:8]     = dev7[HI-1:0];
                st_d              = LS_DEV_ACK;
              end else begin
                st_d = LS_IDLE;
              end
            end else if (st_q == LS_WADDR) begin
              pull_d     = 1'b1;
              ptr_d[7:0] = sh_q;
              buf_clr    = 1'b1;
              st_d       = LS_WADDR_ACK;
            end else begin
              pull_d                = 1'b1;
              buf_we                = 1'b1;
              have_d                = 1'b1;
              ptr_d[PAGE_AW-1:0]    = ptr_q[PAGE_AW-1:0] + 1'b1;
              st_d                  = LS_WDATA_ACK;
            end
          end
        end
        LS_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d   = rd_data;
              pull_d = !rd_data[7];
              st_d   = LS_RDATA;
            end else begin
              pull_d = 1'b0;
              st_d   = LS_WADDR;
            end
          end
        end
        LS_WADDR_ACK, LS_WDATA_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            st_d   = LS_WDATA;
          end
        end
        LS_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              pull_d = 1'b0;
              ptr_d  = ptr_q + 1'b1;
              st_d   = LS_RACK;
            end else begin
              cnt_d  = cnt_q + 4'd1;
              tx_d   = {tx_q[6:0], 1'b0};
              pull_d = !tx_q[6];
            end
          end
        end
        LS_RACK: begin
          if (scl_rise) begin
            mack_d = !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d   = rd_data;
              pull_d = !rd_data[7];
              cnt_d  = '0;
              st_d   = LS_RDATA;
            end else begin
              pull_d = 1'b0;
              st_d   = LS_IDLE;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_IDLE;
      sh_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      have_q <= 1'b0;
      mack_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      have_q <= have_d;
      mack_q <= mack_d;
      pull_q <= pull_d;
    end
  end

  assign sda_pull    = pull_q;
  assign ptr         = ptr_q;
  assign buf_idx     = ptr_q[PAGE_AW-1:0];
  assign buf_data    = sh_q;
  assign commit_page = ptr_q[AW-1:PAGE_AW];
endmodule

// File: rtl/eep_pagebuf.sv
// Page buffer with byte-valid mask and the self-timed write cycle.
// WR_CYCLES must be at least the page size: the buffer is walked in the
// first cycles of the write cycle.
module eep_pagebuf #(
  parameter int AW        = 10,
  parameter int PAGE_AW   = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [PAGE_AW-1:0]    idx,
  input  logic [7:0]            data,
  input  logic                  commit,
  input  logic [AW-PAGE_AW-1:0] page,
  output logic                  busy,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [7:0]            mem_data
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int CW   = $clog2(WR_CYCLES + 1);

  logic [PAGE-1:0][7:0]       entries;
  logic [PAGE-1:0]            mask_q, mask_d;
  logic                       busy_q, busy_d;
  logic [CW-1:0]              tcnt_q, tcnt_d;
  logic [AW-PAGE_AW-1:0]      base_q, base_d;
  logic [PAGE_AW-1:0]         slot;
  logic                       in_walk;

  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    logic [7:0] ent_q;
    logic       ent_en;
    assign ent_en = we && (idx == PAGE_AW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= data;
    end
    assign entries[g] = ent_q;
  end

  always_comb begin
    mask_d = mask_q;
    if (clr) mask_d = '0;
    if (we)  mask_d[idx] = 1'b1;
  end

  always_comb begin
    busy_d = busy_q;
    tcnt_d = tcnt_q;
    base_d = base_q;
    if (commit) begin
      busy_d = 1'b1;
      tcnt_d = '0;
      base_d = page;
    end else if (busy_q) begin
      tcnt_d = tcnt_q + 1'b1;
      if (tcnt_q == CW'(WR_CYCLES - 1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      busy_q <= 1'b0;
      tcnt_q <= '0;
      base_q <= '0;
    end else begin
      mask_q <= mask_d;
      busy_q <= busy_d;
      tcnt_q <= tcnt_d;
      base_q <= base_d;
    end
  end

  assign slot     = tcnt_q[PAGE_AW-1:0];
  assign in_walk  = tcnt_q < CW'(PAGE);
  assign busy     = busy_q;
  assign mem_we   = busy_q && in_walk && mask_q[slot];
  assign mem_addr = {base_q, slot};
  assign mem_data = entries[slot];
endmodule

// File: rtl/eep_array.sv
// Byte array: one synchronous write port, one combinational read port.
module eep_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
  parameter int         AW          = 10,
  parameter int         PAGE_AW     = 4,
  parameter logic [6:0] DEV_BASE    = 7'h50,
  parameter int         WR_CYCLES   = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);
  localparam int PW = AW - PAGE_AW;

  logic [1:0]          rs_q;
  logic                rst_n_s;
  logic                sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                busy, dev_ack;
  logic [7:0]          rd_data;
  logic [AW-1:0]       ptr;
  logic                buf_clr, buf_we, commit;
  logic [PAGE_AW-1:0]  buf_idx;
  logic [7:0]          buf_data;
  logic [PW-1:0]       commit_page;
  logic                mem_we;
  logic [AW-1:0]       mem_addr;
  logic [7:0]          mem_data;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  eep_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_link #(.AW(AW), .PAGE_AW(PAGE_AW), .DEV_BASE(DEV_BASE)) u_link (
    .clk(clk), .rst_n(rst_n_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s), .busy(busy),
    .rd_data(rd_data), .sda_pull(sda_pull), .ptr(ptr), .buf_clr(buf_clr),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data), .commit(commit),
    .commit_page(commit_page), .dev_ack(dev_ack)
  );

  eep_pagebuf #(.AW(AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_pbuf (
    .clk(clk), .rst_n(rst_n_s), .clr(buf_clr), .we(buf_we), .idx(buf_idx),
    .data(buf_data), .commit(commit), .page(commit_page), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  eep_array #(.AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
    .raddr(ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk #(
  parameter int WR_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_pull,
  input logic busy,
  input logic mem_we,
  input logic stop_det,
  input logic dev_ack
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R7
  busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> !busy);

  // R7
  cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WR_CYCLES);

  // R6
  commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R6
  array_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_in);
endmodule

bind eep_i2c_target eep_i2c_target_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_in(scl_in), .sda_pull(sda_pull),
  .busy(busy), .mem_we(mem_we), .stop_det(stop_det), .dev_ack(dev_ack)
);

// File: tb/test_eep_i2c_target.sv
module test_eep_i2c_target;
  localparam int WR = 1000;
  localparam int QC = 10;  // clocks per quarter bit

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, scl_m, sda_m, sda_pull, sda_line;
  assign sda_line = sda_m & ~sda_pull;

  eep_i2c_target #(.WR_CYCLES(WR)) i_eep_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int r10_viol = 0;
  logic prev_pull = 1'b0;
  logic [7:0] model [1024];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always @(negedge clk) begin
    if (rst_n && (sda_pull !== prev_pull) && scl_m) r10_viol++;
    prev_pull <= sda_pull;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n * QC) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1); sda_m = 1'b0; qw(1); scl_m = 1'b0; qw(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw(1); scl_m = 1'b1; qw(1); sda_m = 1'b1; qw(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(1); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(1);
    end
    sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1); ack = !sda_line; qw(1);
    scl_m = 1'b0; qw(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(1); scl_m = 1'b1; qw(1); b[i] = sda_line; qw(1); scl_m = 1'b0;
    end
    qw(1);
    sda_m = !give_ack; qw(1); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(1);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_byte(input logic [1:0] hi, input logic rd);
    return {5'b10100, hi, rd};
  endfunction

  // address-only poll; returns whether the device address was acknowledged
  task automatic poll(input logic [7:0] db, output logic ack);
    bus_start; send_byte(db, ack); bus_stop;
  endtask

  task automatic write_seq(input logic [9:0] addr, input int n, input logic do_wait);
    logic ack;
    bus_start;
    send_byte(dev_byte(addr[9:8], 1'b0), ack); check("R4 device ack on write", ack, 1);
    send_byte(addr[7:0], ack);                 check("R4 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (!ack) check("R4 data ack", ack, 1);
      model[{addr[9:4], 4'(addr[3:0] + 4'(i))}] = wbuf[i];
    end
    bus_stop;
    if (do_wait) repeat (WR + 50) @(negedge clk);
  endtask

  task automatic read_rand(input logic [9:0] addr, input int n);
    logic ack;
    bus_start;
    send_byte(dev_byte(addr[9:8], 1'b0), ack); check("R8 device ack", ack, 1);
    send_byte(addr[7:0], ack);                 check("R8 word address ack", ack, 1);
    bus_start;
    send_byte(dev_byte(addr[9:8], 1'b1), ack); check("R8 read ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop;
  endtask

  task automatic read_cur(input logic [1:0] hi, input int n);
    logic ack;
    bus_start;
    send_byte(dev_byte(hi, 1'b1), ack); check("R9 current read ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop;
  endtask

  task automatic t_reset;
    logic ack;
    check("R1 SDA released after reset", sda_pull, 0);
    poll(dev_byte(2'b00, 1'b0), ack);
    check("R1 address acked after reset", ack, 1);
  endtask

  task automatic t_byte_write;
    wbuf[0] = 8'h5C; write_seq(10'h2A5, 1, 1'b1);
    wbuf[0] = 8'h33; write_seq(10'h0A5, 1, 1'b1);
    read_rand(10'h2A5, 1); check("R2 high bits from device address", rbuf[0], 8'h5C);
    read_rand(10'h0A5, 1); check("R8 random read", rbuf[0], 8'h33);
  endtask

  task automatic t_busy;
    logic ack;
    wbuf[0] = 8'hE1; write_seq(10'h3FF, 1, 1'b0);
    poll(dev_byte(2'b00, 1'b0), ack); check("R7 NAK during write cycle", ack, 0);
    repeat (WR + 50) @(negedge clk);
    poll(dev_byte(2'b00, 1'b0), ack); check("R7 ACK after write cycle", ack, 1);
    wbuf[0] = 8'h1E; write_seq(10'h000, 1, 1'b1);
  endtask

  task automatic t_rollover;
    read_rand(10'h3FF, 2);
    check("R9 byte at 1023", rbuf[0], model[10'h3FF]);
    check("R9 rollover to 0", rbuf[1], model[10'h000]);
  endtask

  task automatic t_page;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h40 + i);
    write_seq(10'h130, 16, 1'b1);
    read_rand(10'h130, 16);
    for (int i = 0; i < 16; i++) check("R5 full page", rbuf[i], model[10'h130 + i]);
  endtask

  task automatic t_current;
    read_rand(10'h130, 1);
    read_cur(2'b01, 2);
    check("R9 current address read", rbuf[0], model[10'h131]);
    check("R9 current address next", rbuf[1], model[10'h132]);
  endtask

  task automatic t_wrap;
    wbuf[0] = 8'h77; write_seq(10'h200, 1, 1'b1);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hA0 + i);
    write_seq(10'h1FE, 4, 1'b1);
    read_rand(10'h1F0, 2);
    check("R5 wrap to page start", rbuf[0], 8'hA2);
    check("R5 wrap second byte", rbuf[1], 8'hA3);
    read_rand(10'h1FE, 3);
    check("R5 first bytes", rbuf[0], 8'hA0);
    check("R5 page end", rbuf[1], 8'hA1);
    check("R5 next page untouched", rbuf[2], 8'h77);
  endtask

  task automatic t_overfill;
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h80 + i);
    write_seq(10'h040, 18, 1'b1);
    read_rand(10'h040, 16);
    check("R5 overwrite offset 0", rbuf[0], 8'h90);
    check("R5 overwrite offset 1", rbuf[1], 8'h91);
    for (int i = 2; i < 16; i++) check("R5 overfill rest", rbuf[i], model[10'h040 + i]);
  endtask

  task automatic t_reject;
    logic ack;
    poll(8'hB0, ack); check("R3 register space NAK", ack, 0);
    bus_start; send_byte(8'hB0, ack); send_byte(8'hA5, ack); send_byte(8'h00, ack); bus_stop;
    poll(8'hE0, ack); check("R2 foreign address NAK", ack, 0);
    poll(dev_byte(2'b10, 1'b0), ack); check("R3 no write cycle started", ack, 1);
    read_rand(10'h2A5, 1); check("R3 array unchanged", rbuf[0], 8'h5C);
  endtask

  task automatic t_nodata;
    logic ack;
    logic [7:0] junk;
    wbuf[0] = 8'h11; write_seq(10'h060, 1, 1'b1);
    bus_start;
    send_byte(dev_byte(2'b00, 1'b0), ack); send_byte(8'h60, ack);
    bus_stop;
    poll(dev_byte(2'b00, 1'b0), ack); check("R6 STOP without data starts no cycle", ack, 1);
    bus_start;
    send_byte(dev_byte(2'b00, 1'b0), ack); send_byte(8'h60, ack); send_byte(8'h99, ack);
    bus_start;
    send_byte(dev_byte(2'b00, 1'b1), ack); recv_byte(1'b0, junk);
    bus_stop;
    poll(dev_byte(2'b00, 1'b0), ack); check("R6 repeated START starts no cycle", ack, 1);
    read_rand(10'h060, 1); check("R6 discarded data", rbuf[0], 8'h11);
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset;
    t_byte_write;
    t_busy;
    t_rollover;
    t_page;
    t_current;
    t_wrap;
    t_overfill;
    t_reject;
    t_nodata;
    check("R10 SDA drive changed only with SCL low", r10_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule